// File: doc/BRIEF.md
# Multicycle 16-bit Register-Machine Core

This block is a small 16-bit processor core with its own 16-opcode instruction set and eight architectural registers. It fetches one 16-bit instruction word per instruction from a single word-addressed memory port, then executes it in a second cycle. The second cycle may read the port, write it, or leave it idle. The registers are three general-purpose registers, a settings register, a 16-bit HL pointer, a flag register, a stack pointer and the program counter. Every register, including PC, SP and the flags, is a legal destination for ordinary moves and ALU operations.

Loads and stores reach either RAM or a separate port space. Bit 0 of the settings register chooses between them, and the choice appears on a dedicated select output. HL is built one byte at a time by two byte-insert opcodes. The stack grows downward from the top of the address space. Once HALT executes, the core parks and raises its halted output.

Top module: `cpu16_core`

## Requirements
- R1: After reset, all eight registers hold zero, `halted_o` is low, no write is issued, and the first fetch reads address 0x0000.
- R2: Each instruction takes one fetch cycle and one execute cycle. During fetch, `mem_addr_o` carries PC and there is no write and no port select. The instruction word is laid out as opcode[15:12], destination[11:9], immediate flag[8], and then either imm8[7:0] or a source register in [2:0]. The immediate is zero-extended. Opcodes: 0 NOP, 1 HALT, 2 MW, 3 MWL, 4 MWH, 5 LW, 6 SW, 7 ADD, 8 SUB, 9 AND, A OR, B NOT, C JMPZ, D JMPN, E PUSH, F POP.
- R3: MW copies the operand to the destination. ADD, SUB (destination minus operand), AND and OR combine the destination with the operand. NOT writes the complement of the operand. All of them wrap at 16 bits.
- R4: ALU opcodes (7 to B) set the flag register to Z in bit 1 and N (result bit 15) in bit 0, with all other bits cleared. MW, LW, POP and the byte inserts leave the flags alone.
- R5: MWL replaces HL[7:0] and MWH replaces HL[15:8] with imm8. The other byte is kept.
- R6: LW and SW address the word at imm8 when the immediate flag is set, and at HL otherwise. `mem_io_o` equals settings-register bit 0 during their execute cycle, so 1 selects the port space. SW writes the destination register.
- R7: JMPZ jumps to the operand when Z is set and JMPN jumps to the operand when N is set. Otherwise PC advances by one.
- R8: PUSH decrements SP and then writes the operand at the new SP. POP reads at SP, then increments SP and writes the destination. Stack traffic never selects the port space. The first push after reset lands at 0xFFFF.
- R9: After HALT, `halted_o` stays high, no further write occurs, and `mem_addr_o` holds the address of the HALT instruction.
- R10: An instruction whose destination is PC (code 7) takes the written value as the next PC instead of PC+1.
- R11: Register codes are A=0, B=1, C=2, settings=3, HL=4, flags=5, SP=6, PC=7. As a source, PC reads the address of the executing instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Word address for fetch, load, store and stack |
| mem_wdata_o | output | 16 | Store data |
| mem_rdata_i | input | 16 | Read data, valid in the same cycle as the address |
| mem_we_o | output | 1 | Write strobe, one cycle |
| mem_io_o | output | 1 | 1 selects port space for the current access |
| halted_o | output | 1 | Core has executed HALT |

## Verification
The only visible state is the stream of writes and the final halt address. A corrupted register therefore shows up only when a later store or push carries it out, or when a jump sends the fetch stream somewhere else. Each program ends by pushing every register, so any wrong internal value appears in the write trace within a few cycles of HALT, and the halt address exposes PC errors. A trace compared write by write against an instruction-level model pins each mismatch to the access that first went wrong. The write-cycle numbers also catch any drift in the two-cycle timing.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int unsigned DW     = 16;
  localparam int unsigned NREG   = 8;
  localparam int unsigned RSEL_W = $clog2(NREG);
  localparam int unsigned IMM_W  = 8;

  typedef enum logic [3:0] {
    OP_NOP, OP_HALT, OP_MW, OP_MWL, OP_MWH, OP_LW, OP_SW, OP_ADD,
    OP_SUB, OP_AND, OP_OR, OP_NOT, OP_JZ, OP_JN, OP_PUSH, OP_POP
  } op_e;

  localparam logic [RSEL_W-1:0] R_A  = 3'd0;
  localparam logic [RSEL_W-1:0] R_B  = 3'd1;
  localparam logic [RSEL_W-1:0] R_C  = 3'd2;
  localparam logic [RSEL_W-1:0] R_SR = 3'd3;
  localparam logic [RSEL_W-1:0] R_HL = 3'd4;
  localparam logic [RSEL_W-1:0] R_FL = 3'd5;
  localparam logic [RSEL_W-1:0] R_SP = 3'd6;
  localparam logic [RSEL_W-1:0] R_PC = 3'd7;

  localparam int unsigned FL_Z  = 1;
  localparam int unsigned FL_N  = 0;
  localparam int unsigned SR_IO = 0;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} state_e;

  typedef struct packed {
    op_e               op;
    logic [RSEL_W-1:0] rd;
    logic              imm;
    logic [IMM_W-1:0]  val;
  } instr_t;
endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         neg_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_NOT:  res_o = ~b_i;
      default: res_o = b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
  assign neg_o  = res_o[W-1];
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
  import cpu16_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter int unsigned N = NREG,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [SW-1:0]       wr_sel_i,
  input  logic [W-1:0]        wr_data_i,
  input  logic                pc_en_i,
  input  logic [W-1:0]        pc_next_i,
  input  logic                sp_en_i,
  input  logic [W-1:0]        sp_next_i,
  input  logic                flag_en_i,
  input  logic [W-1:0]        flag_next_i,
  output logic [N-1:0][W-1:0] regs_o
);
  // priority per register: flag update > generic write > PC/SP side update
  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [SW-1:0] IDX = SW'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_o[g] <= '0;
      else if (flag_en_i && IDX == R_FL)             regs_o[g] <= flag_next_i;
      else if (wr_en_i && wr_sel_i == IDX)           regs_o[g] <= wr_data_i;
      else if (pc_en_i && IDX == R_PC)               regs_o[g] <= pc_next_i;
      else if (sp_en_i && IDX == R_SP)               regs_o[g] <= sp_next_i;
    end
  end
endmodule

// File: rtl/cpu16_seq.sv
module cpu16_seq
  import cpu16_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rdata_i,
  input  logic          halt_req_i,
  output state_e        state_o,
  output instr_t        ir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_FETCH;
      ir_o    <= '0;
    end else begin
      unique case (state_o)
        ST_FETCH: begin
          ir_o    <= instr_t'(rdata_i);
          state_o <= ST_EXEC;
        end
        ST_EXEC: state_o <= halt_req_i ? ST_HALT : ST_FETCH;
        default: state_o <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [15:0]   mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic          mem_we_o,
  output logic          mem_io_o,
  output logic          halted_o
);
  state_e                 state;
  instr_t                 ir;
  logic [NREG-1:0][DW-1:0] regs;
  logic                   halt_req;

  logic              wr_en, pc_en, sp_en, flag_en;
  logic [RSEL_W-1:0] wr_sel;
  logic [DW-1:0]     wr_data, pc_next, sp_next, flag_next;
  logic [DW-1:0]     opnd_a, opnd_b, eff_addr, sp_dec, alu_res;
  logic              alu_z, alu_n;

  cpu16_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rdata_i    (mem_rdata_i),
    .halt_req_i (halt_req),
    .state_o    (state),
    .ir_o       (ir)
  );

  cpu16_regfile #(.W(DW), .N(NREG)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .pc_en_i     (pc_en),
    .pc_next_i   (pc_next),
    .sp_en_i     (sp_en),
    .sp_next_i   (sp_next),
    .flag_en_i   (flag_en),
    .flag_next_i (flag_next),
    .regs_o      (regs)
  );

  localparam logic [DW-IMM_W-1:0] ZEXT = '0;

  assign opnd_a   = regs[ir.rd];
  assign opnd_b   = ir.imm ? {ZEXT, ir.val} : regs[ir.val[RSEL_W-1:0]];
  assign eff_addr = ir.imm ? {ZEXT, ir.val} : regs[R_HL];
  assign sp_dec   = regs[R_SP] - 1'b1;

  cpu16_alu #(.W(DW)) u_alu (
    .op_i   (ir.op),
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .res_o  (alu_res),
    .zero_o (alu_z),
    .neg_o  (alu_n)
  );

  always_comb begin
    flag_next        = '0;
    flag_next[FL_Z]  = alu_z;
    flag_next[FL_N]  = alu_n;
  end

  always_comb begin
    mem_addr_o  = regs[R_PC];
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    mem_io_o    = 1'b0;
    wr_en       = 1'b0;
    wr_sel      = ir.rd;
    wr_data     = alu_res;
    pc_en       = 1'b0;
    pc_next     = regs[R_PC] + 1'b1;
    sp_en       = 1'b0;
    sp_next     = regs[R_SP];
    flag_en     = 1'b0;
    halt_req    = 1'b0;
    if (state == ST_EXEC) begin
      pc_en = 1'b1;
      unique case (ir.op)
        OP_NOP: ;
        OP_HALT: begin
          halt_req = 1'b1;
          pc_en    = 1'b0;
        end
        OP_MW: begin
          wr_en   = 1'b1;
          wr_data = opnd_b;
        end
        OP_MWL: begin
          wr_en   = 1'b1;
          wr_sel  = R_HL;
          wr_data = {regs[R_HL][DW-1:IMM_W], ir.val};
        end
        OP_MWH: begin
          wr_en   = 1'b1;
          wr_sel  = R_HL;
          wr_data = {ir.val, regs[R_HL][IMM_W-1:0]};
        end
        OP_LW: begin
          mem_addr_o = eff_addr;
          mem_io_o   = regs[R_SR][SR_IO];
          wr_en      = 1'b1;
          wr_data    = mem_rdata_i;
        end
        OP_SW: begin
          mem_addr_o  = eff_addr;
          mem_io_o    = regs[R_SR][SR_IO];
          mem_we_o    = 1'b1;
          mem_wdata_o = opnd_a;
        end
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT: begin
          wr_en   = 1'b1;
          flag_en = 1'b1;
        end
        OP_JZ: if (regs[R_FL][FL_Z]) pc_next = opnd_b;
        OP_JN: if (regs[R_FL][FL_N]) pc_next = opnd_b;
        OP_PUSH: begin
          sp_en       = 1'b1;
          sp_next     = sp_dec;
          mem_addr_o  = sp_dec;
          mem_we_o    = 1'b1;
          mem_wdata_o = opnd_b;
        end
        OP_POP: begin
          mem_addr_o = regs[R_SP];
          sp_en      = 1'b1;
          sp_next    = regs[R_SP] + 1'b1;
          wr_en      = 1'b1;
          wr_data    = mem_rdata_i;
        end
        default: ;
      endcase
    end
  end

  assign halted_o = (state == ST_HALT);
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input state_e                  state,
  input instr_t                  ir,
  input logic [NREG-1:0][DW-1:0] regs,
  input logic [15:0]             mem_addr_o,
  input logic                    mem_we_o,
  input logic                    mem_io_o,
  input logic                    halted_o
);
  logic exec_alu;
  assign exec_alu = (state == ST_EXEC) && (ir.op >= OP_ADD) && (ir.op <= OP_NOT);

  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  a_r9_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);

  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && $past(halted_o)) |-> $stable(mem_addr_o));

  a_r2_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH) |=> (state != ST_FETCH));

  a_r2_fetch_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH) |-> (!mem_we_o && !mem_io_o));

  a_r4_flags_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_alu && ir.rd != R_FL && ir.rd != R_PC) |=>
      (regs[R_FL][FL_Z] == (regs[$past(ir.rd)] == '0)) &&
      (regs[R_FL][FL_N] == regs[$past(ir.rd)][DW-1]));

  a_r7_nop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && ir.op == OP_NOP) |=> regs[R_PC] == $past(regs[R_PC]) + 16'd1);

  a_r8_push_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && ir.op == OP_PUSH) |=> regs[R_SP] == $past(regs[R_SP]) - 16'd1);

  a_r8_stack_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && (ir.op == OP_PUSH || ir.op == OP_POP)) |-> !mem_io_o);
endmodule

bind cpu16_core cpu16_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state      (state),
  .ir         (ir),
  .regs       (regs),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_io_o   (mem_io_o),
  .halted_o   (halted_o)
);

// File: tb/tb_cpu16_core.sv
`timescale 1ns/1ps
module tb_cpu16_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_q = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, mem_io, halted;

  always #10 clk = ~clk;

  cpu16_core dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_io_o(mem_io), .halted_o(halted)
  );

  // memory model: 2 x 256 words aliased on addr[15] and addr[7:0]; 256-word port space
  logic [15:0] img [512];
  logic [15:0] img_io [256];
  logic [15:0] mem [512];
  logic [15:0] iom [256];
  logic [15:0] lg_a [64];
  logic [15:0] lg_d [64];
  logic        lg_io [64];
  int          lg_cyc [64];
  int          wr_cnt, cyc;

  always_comb mem_rdata = mem_io ? iom[mem_addr[7:0]] : mem[{mem_addr[15], mem_addr[7:0]}];

  always @(posedge clk) begin
    if (load_q) begin
      for (int i = 0; i < 512; i++) mem[i] <= img[i];
      for (int i = 0; i < 256; i++) iom[i] <= img_io[i];
      wr_cnt <= 0;
      cyc    <= 0;
    end else if (rst_n) begin
      cyc <= cyc + 1;
      if (mem_we) begin
        if (mem_io) iom[mem_addr[7:0]] <= mem_wdata;
        else        mem[{mem_addr[15], mem_addr[7:0]}] <= mem_wdata;
        if (wr_cnt < 64) begin
          lg_a[wr_cnt]   <= mem_addr;
          lg_d[wr_cnt]   <= mem_wdata;
          lg_io[wr_cnt]  <= mem_io;
          lg_cyc[wr_cnt] <= cyc;
        end
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam logic [3:0] NOP=0, HALT=1, MW=2, MWL=3, MWH=4, LW=5, SW=6, ADD=7,
                         SUB=8, AND=9, OR=10, NOT=11, JZ=12, JN=13, PUSH=14, POP=15;

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] rd,
                                      input logic im, input logic [7:0] v);
    return {op, rd, im, v};
  endfunction

  int pc_w;
  task automatic put(input logic [15:0] w);
    img[pc_w] = w;
    pc_w++;
  endtask

  task automatic clear_img();
    for (int i = 0; i < 512; i++) img[i] = 16'h0;
    for (int i = 0; i < 256; i++) img_io[i] = 16'h0;
    pc_w = 0;
  endtask

  // instruction-level reference model
  logic [15:0] mm [512];
  logic [15:0] mio [256];
  logic [15:0] mr [8];
  logic [15:0] ex_a [64];
  logic [15:0] ex_d [64];
  logic        ex_io [64];
  int          ex_n;
  logic [15:0] ex_pc;

  task automatic m_store(input logic [15:0] a, input logic [15:0] d, input logic io);
    if (io) mio[a[7:0]] = d;
    else    mm[{a[15], a[7:0]}] = d;
    if (ex_n < 64) begin
      ex_a[ex_n] = a; ex_d[ex_n] = d; ex_io[ex_n] = io;
    end
    ex_n++;
  endtask

  task automatic m_wr(input logic [2:0] r, input logic [15:0] v, inout logic [15:0] npc);
    if (r == 3'd7) npc = v;
    else           mr[r] = v;
  endtask

  task automatic model_run();
    logic [15:0] ir, b, ea, npc, res, d;
    logic [3:0]  op;
    logic [2:0]  rd;
    logic [7:0]  v;
    bit          done;
    for (int i = 0; i < 512; i++) mm[i] = img[i];
    for (int i = 0; i < 256; i++) mio[i] = img_io[i];
    for (int i = 0; i < 8; i++) mr[i] = 16'h0;
    ex_n = 0;
    done = 0;
    for (int s = 0; s < 3000 && !done; s++) begin
      ir  = mm[{mr[7][15], mr[7][7:0]}];
      op  = ir[15:12]; rd = ir[11:9]; v = ir[7:0];
      b   = ir[8] ? {8'h00, v} : mr[ir[2:0]];
      ea  = ir[8] ? {8'h00, v} : mr[4];
      npc = mr[7] + 16'd1;
      case (op)
        HALT: begin done = 1; npc = mr[7]; end
        MW:   m_wr(rd, b, npc);
        MWL:  m_wr(3'd4, {mr[4][15:8], v}, npc);
        MWH:  m_wr(3'd4, {v, mr[4][7:0]}, npc);
        LW: begin
          d = mr[3][0] ? mio[ea[7:0]] : mm[{ea[15], ea[7:0]}];
          m_wr(rd, d, npc);
        end
        SW:   m_store(ea, (rd == 3'd7) ? mr[7] : mr[rd], mr[3][0]);
        ADD, SUB, AND, OR, NOT: begin
          case (op)
            ADD:     res = mr[rd] + b;
            SUB:     res = mr[rd] - b;
            AND:     res = mr[rd] & b;
            OR:      res = mr[rd] | b;
            default: res = ~b;
          endcase
          m_wr(rd, res, npc);
          mr[5] = {14'd0, res == 16'h0, res[15]};
        end
        JZ:   if (mr[5][1]) npc = b;
        JN:   if (mr[5][0]) npc = b;
        PUSH: begin
          mr[6] = mr[6] - 16'd1;
          m_store(mr[6], b, 1'b0);
        end
        POP: begin
          d = mm[{mr[6][15], mr[6][7:0]}];
          mr[6] = mr[6] + 16'd1;
          m_wr(rd, d, npc);
        end
        default: ;
      endcase
      mr[7] = npc;
    end
    ex_pc = mr[7];
  endtask

  // load image, check reset state (R1), run to halt, compare trace and halt PC
  task automatic run_prog(input string name);
    int lim;
    model_run();
    rst_n  = 1'b0;
    load_q = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_q = 1'b0;
    chk(mem_addr == 16'h0 && !mem_we && !halted, {"R1 reset state ", name},
        {mem_addr, 7'd0, mem_we, 7'd0, halted}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    chk(mem_addr == 16'h0 && !mem_we && !mem_io, {"R2 first fetch ", name},
        {mem_addr, 15'd0, mem_we}, 32'h0);
    lim = 0;
    while (!halted && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    repeat (12) @(negedge clk);
    chk(wr_cnt == ex_n, {"R9 write count ", name}, wr_cnt, ex_n);
    for (int i = 0; i < ex_n && i < 64 && i < wr_cnt; i++)
      chk(lg_a[i] == ex_a[i] && lg_d[i] == ex_d[i] && lg_io[i] == ex_io[i],
          {"R3 trace ", name}, {lg_a[i], lg_d[i]}, {ex_a[i], ex_d[i]});
    chk(halted && mem_addr == ex_pc, {"R9 halt address ", name},
        {15'd0, halted, mem_addr}, {16'd1, ex_pc});
  endtask

  task automatic hand(input int i, input logic [15:0] a, input logic [15:0] d,
                      input logic io, input string req);
    chk(lg_a[i] == a && lg_d[i] == d && lg_io[i] == io, req,
        {lg_a[i], lg_d[i]}, {a, d});
  endtask

  task automatic gen_random();
    logic [3:0] ops [14];
    logic [3:0] op;
    logic [2:0] rd;
    logic       im;
    logic [7:0] v;
    ops = '{NOP, MW, MWL, MWH, LW, SW, ADD, SUB, AND, OR, NOT, JZ, JN, PUSH};
    clear_img();
    for (int i = 0; i < 512; i++) img[i] = 16'($urandom);
    for (int i = 0; i < 256; i++) img_io[i] = 16'($urandom);
    for (int k = 0; k < 24; k++) begin
      op = ops[$urandom_range(0, 13)];
      rd = 3'($urandom_range(0, 5));
      im = 1'($urandom);
      v  = 8'($urandom);
      if (op == SW) begin im = 1'b1; v[7] = 1'b1; end
      if (op == JZ || op == JN) begin
        im = 1'b1;
        v  = 8'(pc_w + 1 + $urandom_range(0, 2));
      end
      put(enc(op, rd, im, v));
    end
    for (int r = 0; r < 7; r++) put(enc(PUSH, 3'd0, 1'b0, 8'(r)));
    put(enc(HALT, 3'd0, 1'b0, 8'd0));
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // D1: push every register after reset
    clear_img();
    for (int r = 0; r < 8; r++) put(enc(PUSH, 3'd0, 1'b0, 8'(r)));
    put(enc(HALT, 3'd0, 1'b0, 8'd0));
    run_prog("push_all");
    for (int k = 0; k < 6; k++)
      hand(k, 16'hFFFF - 16'(k), 16'h0000, 1'b0, "R1 zero register / R8 stack address");
    hand(6, 16'hFFF9, 16'hFFFA, 1'b0, "R11 SP code 6 reads SP");
    hand(7, 16'hFFF8, 16'h0007, 1'b0, "R11 PC code 7 reads own address");
    for (int k = 0; k < 8; k++)
      chk(lg_cyc[k] == 2 * k + 1, "R2 two-cycle timing", lg_cyc[k], 2 * k + 1);

    // D2: byte inserts, ALU, flags, JMPN
    clear_img();
    put(enc(MWL, 3'd0, 1'b1, 8'h34));
    put(enc(MWH, 3'd0, 1'b1, 8'h12));
    put(enc(PUSH, 3'd0, 1'b0, 8'd4));
    put(enc(MWL, 3'd0, 1'b1, 8'hFF));
    put(enc(PUSH, 3'd0, 1'b0, 8'd4));
    put(enc(MW, 3'd0, 1'b1, 8'd5));
    put(enc(SUB, 3'd0, 1'b1, 8'd7));
    put(enc(PUSH, 3'd0, 1'b0, 8'd5));
    put(enc(NOT, 3'd1, 1'b1, 8'h0F));
    put(enc(PUSH, 3'd0, 1'b0, 8'd1));
    put(enc(JN, 3'd0, 1'b1, 8'd12));
    put(enc(PUSH, 3'd0, 1'b1, 8'hAD));
    put(enc(ADD, 3'd0, 1'b1, 8'd2));
    put(enc(PUSH, 3'd0, 1'b0, 8'd5));
    put(enc(MW, 3'd2, 1'b0, 8'd0));
    put(enc(PUSH, 3'd0, 1'b0, 8'd5));
    put(enc(HALT, 3'd0, 1'b0, 8'd0));
    run_prog("alu_flags");
    hand(0, 16'hFFFF, 16'h1234, 1'b0, "R5 MWL then MWH");
    hand(1, 16'hFFFE, 16'h12FF, 1'b0, "R5 MWL keeps high byte");
    hand(2, 16'hFFFD, 16'h0001, 1'b0, "R4 SUB negative sets N");
    hand(3, 16'hFFFC, 16'hFFF0, 1'b0, "R3 NOT of immediate");
    hand(4, 16'hFFFB, 16'h0002, 1'b0, "R7 JMPN taken, R4 zero sets Z");
    hand(5, 16'hFFFA, 16'h0002, 1'b0, "R4 MW leaves flags");

    // D3: port space vs RAM, HL and imm8 addressing
    clear_img();
    img_io[8'h33] = 16'hBEEF;
    put(enc(MW, 3'd3, 1'b1, 8'd1));
    put(enc(MW, 3'd0, 1'b1, 8'h55));
    put(enc(SW, 3'd0, 1'b1, 8'h10));
    put(enc(LW, 3'd2, 1'b1, 8'h33));
    put(enc(MW, 3'd3, 1'b1, 8'd0));
    put(enc(MWL, 3'd0, 1'b1, 8'h20));
    put(enc(MWH, 3'd0, 1'b1, 8'h80));
    put(enc(SW, 3'd2, 1'b0, 8'd0));
    put(enc(LW, 3'd1, 1'b0, 8'd0));
    put(enc(PUSH, 3'd0, 1'b0, 8'd1));
    put(enc(HALT, 3'd0, 1'b0, 8'd0));
    run_prog("io_select");
    hand(0, 16'h0010, 16'h0055, 1'b1, "R6 store to port space via imm8");
    hand(1, 16'h8020, 16'hBEEF, 1'b0, "R6 port load, RAM store via HL");
    hand(2, 16'hFFFF, 16'hBEEF, 1'b0, "R6 RAM load via HL");

    // D4: push/pop order
    clear_img();
    put(enc(PUSH, 3'd0, 1'b1, 8'h77));
    put(enc(PUSH, 3'd0, 1'b1, 8'h66));
    put(enc(POP, 3'd0, 1'b0, 8'd0));
    put(enc(POP, 3'd1, 1'b0, 8'd0));
    put(enc(PUSH, 3'd0, 1'b0, 8'd0));
    put(enc(PUSH, 3'd0, 1'b0, 8'd1));
    put(enc(PUSH, 3'd0, 1'b0, 8'd6));
    put(enc(HALT, 3'd0, 1'b0, 8'd0));
    run_prog("stack");
    hand(2, 16'hFFFF, 16'h0066, 1'b0, "R8 POP order, SP back to zero");
    hand(3, 16'hFFFE, 16'h0077, 1'b0, "R8 second POP");
    hand(4, 16'hFFFD, 16'hFFFE, 1'b0, "R8 SP decrement before write");

    // D5: JMPZ, write to PC, JMPN not taken
    clear_img();
    put(enc(MW, 3'd0, 1'b1, 8'd0));
    put(enc(ADD, 3'd0, 1'b1, 8'd0));
    put(enc(JZ, 3'd0, 1'b1, 8'd4));
    put(enc(PUSH, 3'd0, 1'b1, 8'hAD));
    put(enc(PUSH, 3'd0, 1'b1, 8'd1));
    put(enc(MW, 3'd7, 1'b1, 8'd7));
    put(enc(PUSH, 3'd0, 1'b1, 8'hAE));
    put(enc(PUSH, 3'd0, 1'b1, 8'd2));
    put(enc(JN, 3'd0, 1'b1, 8'd10));
    put(enc(PUSH, 3'd0, 1'b1, 8'd3));
    put(enc(HALT, 3'd0, 1'b0, 8'd0));
    run_prog("branches");
    chk(wr_cnt == 3, "R7 R10 skipped pushes", wr_cnt, 3);
    hand(0, 16'hFFFF, 16'h0001, 1'b0, "R7 JMPZ taken");
    hand(1, 16'hFFFE, 16'h0002, 1'b0, "R10 MW to PC jumps");
    hand(2, 16'hFFFD, 16'h0003, 1'b0, "R7 JMPN not taken");
    repeat (20) @(negedge clk);
    chk(wr_cnt == 3 && halted && mem_addr == 16'd10, "R9 parked after halt",
        {wr_cnt[15:0], mem_addr}, {16'd3, 16'd10});

    // constrained random programs
    for (int p = 0; p < 10; p++) begin
      gen_random();
      run_prog($sformatf("random_%0d", p));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule